// File: doc/BRIEF.md
# Serial Port Core with Prioritised Interrupt Cause

This block is a byte-wide asynchronous serial port for a simple register bus. Software writes bytes to a transmit holding path and reads received bytes from a receive buffer path. Each path is either a single byte or a 16-entry queue, chosen by a control bit. Frames are one start bit, eight data bits sent least significant bit first, and one stop bit. The receiver oversamples its line at 16 times the bit rate and is always listening for a start bit.

The bit rate comes from a 16-bit divisor held in two byte registers. A downcounter turns the divisor into an oversampling tick. Three interrupt causes are line error, received data and transmit path empty. A status register gives per-byte error flags for the byte at the head of the receive path. An identification register names the highest-priority pending cause. When no interrupt is enabled, software polls the status register instead.

Register addresses: 0 data (write: transmit, read: receive), 1 interrupt enables, 2 read: cause code / write: queue control, 3 line status, 4 divisor low byte, 5 divisor high byte. Reads return data on `bus_rdata` one clock after the read strobe, and a read's side effects take place at that same edge.

Top module: `uart_core`

## Requirements
- R1: After reset, line status (addr 3) reads 0x60, the cause code (addr 2) reads 0x01, `irq` is 0 and `txd` is 1. The divisor resets to 0.
- R2: The divisor is {addr 5, addr 4}. Each serial bit lasts 16 × divisor clocks. A divisor of 0 stops all bit timing, so nothing is sent. Writing either divisor byte restarts the count.
- R3: Transmitted frames are a low start bit, eight data bits LSB first, and a high stop bit.
- R4: The receiver needs no enable. A frame that arrives sets line status bit 0 (data ready), and the byte then reads back from addr 0.
- R5: With queue control bit 0 set (write addr 2), each direction holds 16 bytes. Writes to a full transmit queue are dropped. Any write to addr 2 empties both queues.
- R6: With queue control bit 0 clear, each direction holds one byte, and a second transmit write before the first is sent is dropped.
- R7: A byte that arrives while the receive path is full is discarded and sets line status bit 1 (overrun).
- R8: Line status bit 2 (stop bit low) and bit 3 (all-zero frame with low stop bit) describe the byte at the head of the receive path. Reading line status clears bits 1, 2 and 3.
- R9: Setting enable bit 1 while the transmit path is empty raises the transmit-empty cause at once. The next write to addr 0 clears it. The cause is raised again whenever the transmit path becomes empty.
- R10: Enable bits are 0 for received data, 1 for transmit empty and 2 for line error. The cause code is 0x06 for a line error, 0x04 for data ready and 0x02 for transmit empty, in that priority, and 0x01 when none is pending. `irq` is high while any enabled cause is pending.
- R11: With all enable bits clear, `irq` stays 0 and the cause code reads 0x01 even when data is waiting.
- R12: Reading addr 0 removes one byte, and line status bit 0 clears once the receive path is empty. Bit 5 is set while the transmit path is empty, and bit 6 while the transmitter is also idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
All 256 byte values go through a transmit-to-receive loopback. This shows that bit order and the sampling point are right for every data pattern. Hand-built frames on the receive line, with a low stop bit or all zeros, separate framing errors from breaks. A clean byte queued ahead of a bad one shows that the error flags follow the head byte and not the newest arrival. Timing is measured at two divisor values, one with a nonzero high byte, and a zero divisor is shown to hold the transmitter. Bursts wider than the queue in both queue modes show where writes start to be dropped. A forced overrun with all enables set steps the cause code through every priority level as the causes are cleared.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int OSR      = 16;
  localparam int SUB_W    = $clog2(OSR);
  localparam int DIV_W    = 16;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_CAUSE = 3'd2;
  localparam logic [2:0] A_LSTAT = 3'd3;
  localparam logic [2:0] A_DIVL  = 3'd4;
  localparam logic [2:0] A_DIVH  = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} ser_state_t;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             one_deep,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = one_deep ? !empty : (cnt == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + AW'(1);
      if (do_rd) rp <= rp + AW'(1);
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  // R5: occupancy never passes the queue depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/uart_baud.sv
module uart_baud import uart_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (reload) begin
      cnt  <= div;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt <= DIV_W'(1)) begin
      cnt  <= div;
      tick <= (cnt == DIV_W'(1));
    end else begin
      cnt  <= cnt - DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R2: a zero divisor produces no tick
  p_no_tick_div0_r2: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       pop,
  output logic       idle,
  output logic       txd
);
  ser_state_t       st;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  assign idle = (st == S_IDLE);
  assign pop  = tick && idle && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      sub  <= '0;
      bitn <= '0;
      sh   <= '0;
      txd  <= 1'b1;
    end else if (tick) begin
      if (st == S_IDLE) begin
        if (!q_empty) begin
          st  <= S_START;
          sh  <= q_data;
          sub <= '0;
          txd <= 1'b0;
        end
      end else if (sub != SUB_W'(OSR - 1)) begin
        sub <= sub + SUB_W'(1);
      end else begin
        sub <= '0;
        case (st)
          S_START: begin
            st   <= S_DATA;
            txd  <= sh[0];
            sh   <= sh >> 1;
            bitn <= '0;
          end
          S_DATA: begin
            if (bitn == 3'd7) begin
              st  <= S_STOP;
              txd <= 1'b1;
            end else begin
              txd  <= sh[0];
              sh   <= sh >> 1;
              bitn <= bitn + 3'd1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3: the line is high whenever the shifter is idle
  p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && $past(idle)) |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rxd,
  output logic     push,
  output rx_word_t word
);
  logic             s1, rx_s;
  ser_state_t       st;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic             at_end;

  assign at_end = (sub == SUB_W'(OSR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      s1   <= rxd;
      rx_s <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      sub  <= '0;
      bitn <= '0;
      sh   <= '0;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st  <= S_START;
            sub <= '0;
          end
          S_START: begin
            if (sub == SUB_W'(OSR / 2 - 1)) begin
              st   <= rx_s ? S_IDLE : S_DATA;
              sub  <= '0;
              bitn <= '0;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          S_DATA: begin
            if (at_end) begin
              sub <= '0;
              sh  <= {rx_s, sh[7:1]};
              if (bitn == 3'd7) st <= S_STOP;
              else bitn <= bitn + 3'd1;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          S_STOP: begin
            if (at_end) begin
              sub       <= '0;
              push      <= 1'b1;
              word.data <= sh;
              word.ferr <= !rx_s;
              word.brk  <= !rx_s && (sh == 8'h00);
              st        <= rx_s ? S_IDLE : S_HOLD;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          default: if (rx_s) st <= S_IDLE;
        endcase
      end
    end
  end

  // R8: a break is always also a framing error
  p_break_is_ferr_r8: assert property (@(posedge clk) disable iff (rst)
    (push && word.brk) |-> word.ferr);
endmodule

// File: rtl/uart_core.sv
module uart_core import uart_pkg::*; #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam int WW = $bits(rx_word_t);

  logic [DIV_W-1:0] div;
  logic [2:0]       ien;
  logic             q_on, tick, div_wr, flush;
  logic             tx_empty, tx_full, tx_pop, tx_idle, tx_empty_q, thre_pend;
  logic [7:0]       tx_head;
  logic             rx_push, rx_empty, rx_full, rx_pop, head_seen;
  rx_word_t         rx_in, rx_head;
  logic             lsr_oe, lsr_fe, lsr_bi;
  logic             wr_data, wr_ien, rd_lstat, ls_int, rx_int, tx_int;
  logic [7:0]       lstat, cause;

  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign wr_ien   = bus_wr && (bus_addr == A_IEN);
  assign flush    = bus_wr && (bus_addr == A_CAUSE);
  assign div_wr   = bus_wr && ((bus_addr == A_DIVL) || (bus_addr == A_DIVH));
  assign rd_lstat = bus_rd && (bus_addr == A_LSTAT);
  assign rx_pop   = bus_rd && (bus_addr == A_DATA) && !rx_empty;

  uart_baud i_baud (.clk(clk), .rst(rst), .div(div), .reload(div_wr), .tick(tick));

  uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst(rst), .flush(flush), .one_deep(!q_on),
    .wr_en(wr_data && !tx_full), .wr_data(bus_wdata), .rd_en(tx_pop),
    .rd_data(tx_head), .empty(tx_empty), .full(tx_full));

  uart_tx i_tx (.clk(clk), .rst(rst), .tick(tick), .q_empty(tx_empty), .q_data(tx_head),
    .pop(tx_pop), .idle(tx_idle), .txd(txd));

  uart_rx i_rx (.clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .push(rx_push), .word(rx_in));

  uart_fifo #(.WIDTH(WW), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .flush(flush), .one_deep(!q_on),
    .wr_en(rx_push), .wr_data(rx_in), .rd_en(rx_pop),
    .rd_data(rx_head), .empty(rx_empty), .full(rx_full));

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= '0;
      ien  <= '0;
      q_on <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_IEN:   ien         <= bus_wdata[2:0];
        A_CAUSE: q_on        <= bus_wdata[0];
        A_DIVL:  div[7:0]    <= bus_wdata;
        A_DIVH:  div[15:8]   <= bus_wdata;
        default: ;
      endcase
    end
  end

  // head-of-queue error tracking and sticky line flags
  always_ff @(posedge clk) begin
    if (rst) begin
      head_seen <= 1'b0;
      lsr_oe    <= 1'b0;
      lsr_fe    <= 1'b0;
      lsr_bi    <= 1'b0;
    end else begin
      if (rd_lstat) begin
        lsr_oe <= 1'b0;
        lsr_fe <= 1'b0;
        lsr_bi <= 1'b0;
      end
      if (rx_push && rx_full) lsr_oe <= 1'b1;
      if (flush || rx_pop) begin
        head_seen <= 1'b0;
      end else if (!rx_empty && !head_seen) begin
        head_seen <= 1'b1;
        if (rx_head.ferr) lsr_fe <= 1'b1;
        if (rx_head.brk)  lsr_bi <= 1'b1;
      end
    end
  end

  // transmit-empty cause
  always_ff @(posedge clk) begin
    if (rst) begin
      thre_pend  <= 1'b0;
      tx_empty_q <= 1'b1;
    end else begin
      tx_empty_q <= tx_empty;
      if (wr_data)
        thre_pend <= 1'b0;
      else if ((wr_ien && bus_wdata[1] && tx_empty) || (tx_empty && !tx_empty_q))
        thre_pend <= 1'b1;
    end
  end

  assign ls_int = ien[2] && (lsr_oe || lsr_fe || lsr_bi);
  assign rx_int = ien[0] && head_seen;
  assign tx_int = ien[1] && thre_pend;
  assign lstat  = {1'b0, tx_empty && tx_idle, tx_empty, 1'b0, lsr_bi, lsr_fe, lsr_oe, head_seen};

  always_comb begin
    if (ls_int)      cause = 8'h06;
    else if (rx_int) cause = 8'h04;
    else if (tx_int) cause = 8'h02;
    else             cause = 8'h01;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ls_int || rx_int || tx_int;
      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= rx_empty ? 8'h00 : rx_head.data;
          A_IEN:   bus_rdata <= {5'b0, ien};
          A_CAUSE: bus_rdata <= cause;
          A_LSTAT: bus_rdata <= lstat;
          A_DIVL:  bus_rdata <= div[7:0];
          A_DIVH:  bus_rdata <= div[15:8];
          default: bus_rdata <= 8'h00;
        endcase
      end
    end
  end

  // R3: the shifter only takes a byte that exists
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tx_empty);
  // R11: no request while every cause is masked
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    (ien == 3'b000) |=> !irq);
  // R9: a data write withdraws the transmit-empty cause
  p_thre_clear_r9: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !thre_pend);
  // R7: arrival into a full receive path flags overrun
  p_overrun_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> lsr_oe);
endmodule

// File: tb/test_uart_core.sv
`timescale 1ns/1ps
module test_uart_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       txd, irq, rxd_drv = 1'b1, loop = 1'b0;
  logic       rxd;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  assign rxd = loop ? txd : rxd_drv;
  always #4 clk = ~clk;

  uart_core i_uart_core (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_div(input logic [15:0] d);
    wr(3'd4, d[7:0]); wr(3'd5, d[15:8]);
  endtask

  task automatic wait_dr(output logic [7:0] l);
    l = 8'h00;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, l);
      if (l[0]) break;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    @(negedge clk); rxd_drv = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_drv = d[i]; repeat (16) @(negedge clk); end
    rxd_drv = stop; repeat (16) @(negedge clk);
    rxd_drv = 1'b1; repeat (20) @(negedge clk);
  endtask

  task automatic low_len(output int n);
    n = 0;
    for (int i = 0; i < 1000 && txd; i++) @(negedge clk);
    while (!txd && n < 20000) begin n++; @(negedge clk); end
  endtask

  initial begin
    logic [7:0] v, l;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd3, v); chk("R1 line status", v, 8'h60);
    rd(3'd2, v); chk("R1 cause", v, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 txd", txd, 1);

    // R2 zero divisor holds the transmitter
    wr(3'd0, 8'h55); repeat (300) @(negedge clk);
    chk("R2 txd held", txd, 1);
    rd(3'd3, v); chk("R2 byte still queued", v, 8'h00);
    // R3 frame format, decoded at mid-bit with divisor 1
    set_div(16'd1);
    for (int i = 0; i < 1000 && txd; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R3 start bit", txd, 0);
    v = '0;
    for (int i = 0; i < 8; i++) begin repeat (16) @(negedge clk); v[i] = txd; end
    chk("R3 data LSB first", v, 8'h55);
    repeat (16) @(negedge clk); chk("R3 stop bit", txd, 1);
    repeat (40) @(negedge clk);

    // R2 bit timing: 0x00 keeps line low for start + 8 bits
    set_div(16'd3); wr(3'd0, 8'h00); low_len(n);
    chk("R2 low span div 3", n, 9 * 16 * 3);
    repeat (60) @(negedge clk);
    set_div(16'h0101); wr(3'd0, 8'hFF); low_len(n);
    chk("R2 start span div 0x0101", n, 16 * 257);
    set_div(16'd1); repeat (300) @(negedge clk);

    // R9 transmit-empty cause
    set_div(16'd0);
    wr(3'd1, 8'h02); @(negedge clk);
    chk("R9 irq on enable", irq, 1);
    rd(3'd2, v); chk("R9 cause tx empty", v, 8'h02);
    wr(3'd0, 8'h99); @(negedge clk);
    chk("R9 irq cleared by write", irq, 0);
    rd(3'd2, v); chk("R9 cause none", v, 8'h01);
    wr(3'd1, 8'h00); set_div(16'd1); repeat (300) @(negedge clk);

    // R4 loopback sweep of every byte, single-byte mode
    loop = 1'b1;
    for (int b = 0; b < 256; b++) begin
      wr(3'd0, 8'(b)); wait_dr(l);
      chk("R4 ready, no error", l[4:0], 5'h01);
      rd(3'd0, v); chk("R4 byte value", v, b);
    end
    repeat (100) @(negedge clk);
    rd(3'd3, v); chk("R12 ready clears after read", v, 8'h60);

    // R5 deep queues: 18 writes, 16 kept
    wr(3'd2, 8'h01); set_div(16'd0);
    for (int i = 0; i < 18; i++) wr(3'd0, 8'(8'h40 + i));
    set_div(16'd1); repeat (3200) @(negedge clk);
    rd(3'd3, v); chk("R5 all sent, data waiting", v, 8'h61);
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, v); chk("R5 queued order", v, 8'h40 + i);
    end
    rd(3'd3, v); chk("R12 queue drained", v, 8'h60);

    // R6 single-byte holding drops a second write
    wr(3'd2, 8'h00); set_div(16'd0);
    wr(3'd0, 8'h71); wr(3'd0, 8'h72);
    set_div(16'd1); repeat (500) @(negedge clk);
    rd(3'd0, v); chk("R6 first byte kept", v, 8'h71);
    rd(3'd3, v); chk("R6 second byte dropped", v, 8'h60);

    // R7 overrun and R10 priority stepping
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h11); wait_dr(l);
    wr(3'd0, 8'h22); repeat (300) @(negedge clk);
    rd(3'd2, v); chk("R10 line error first", v, 8'h06);
    chk("R10 irq", irq, 1);
    rd(3'd3, v); chk("R7 overrun flag", v, 8'h63);
    rd(3'd3, v); chk("R8 flags cleared by read", v, 8'h61);
    wr(3'd1, 8'h00); @(negedge clk);
    rd(3'd2, v); chk("R11 cause masked", v, 8'h01);
    chk("R11 irq masked", irq, 0);
    wr(3'd1, 8'h07); @(negedge clk);
    rd(3'd2, v); chk("R10 data ready next", v, 8'h04);
    rd(3'd0, v); chk("R7 first byte kept", v, 8'h11);
    @(negedge clk);
    rd(3'd2, v); chk("R10 tx empty last", v, 8'h02);
    wr(3'd1, 8'h00);

    // R8 framing error and break on hand-made frames
    loop = 1'b0;
    send_frame(8'h5A, 1'b0); wait_dr(l);
    chk("R8 framing flag", l, 8'h65);
    rd(3'd0, v); chk("R8 framing byte", v, 8'h5A);
    send_frame(8'h00, 1'b0); wait_dr(l);
    chk("R8 break flags", l, 8'h6D);
    rd(3'd0, v); chk("R8 break byte", v, 8'h00);
    // R8 flags follow the head byte
    wr(3'd2, 8'h01);
    send_frame(8'h33, 1'b1); send_frame(8'h44, 1'b0);
    rd(3'd3, v); chk("R8 clean head", v, 8'h61);
    rd(3'd0, v); chk("R8 clean byte", v, 8'h33);
    rd(3'd3, v); chk("R8 bad head", v, 8'h65);
    rd(3'd0, v); chk("R8 bad byte", v, 8'h44);
    rd(3'd3, v); chk("R12 empty after reads", v, 8'h60);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule